// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Holding Register

This block receives asynchronous serial characters on a single input line. A clock enable, `tick`, runs at sixteen times the bit rate and times every decision. The line first passes through a two-stage synchronizer. A low level seen while idle starts a tick counter, and the start bit is checked again half a bit later. A start that has gone high again by then is dropped as a glitch. Data bits go in least significant bit first. Each data bit, the optional parity bit and the stop bit is sampled once, at its centre, sixteen ticks after the previous sample.

When a character finishes, the byte and three error tags are written together into a one-entry, 11-bit holding register. The tags are parity error, framing error and break. The status view always shows the tags of the byte that is currently held. The tags change only when a new character is written in. The host reads the byte through a data strobe and clears the overrun indication through a status strobe. A receive-ready interrupt follows the data-ready flag when its enable is set.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset, `status` is 0, `data_out` is 0 and `irq` is 0.
- R2: A frame is one low start bit, 8 data bits sent LSB first, an optional parity bit and one stop bit, each 16 ticks long. When it completes, `data_out` holds the byte and `status[0]` (data ready) is 1.
- R3: If the line goes low and is high again 8 ticks later (the start-bit centre), no character is produced and `status[0]` does not change.
- R4: When `par_en`=1, the expected parity bit is the XOR of the data for even parity (`par_odd`=0) and its inverse for odd parity (`par_odd`=1). A mismatch sets `status[2]`. When `par_en`=0, `status[2]` is 0 for that character.
- R5: A stop bit sampled low sets `status[3]` (framing error) for that character.
- R6: If every data, parity and stop sample is low, `status[4]` (break) is set together with `status[3]`.
- R7: A character that completes while `status[0]` is still 1 overwrites `data_out` and sets `status[1]` (overrun). A `rd_status` pulse clears `status[1]`.
- R8: A `rd_data` pulse clears `status[0]`. `data_out` and `status[4:2]` keep their values until the next character is written in, so the tags always match the byte held.
- R9: `irq` is 1 exactly when `status[0]` is 1 and `ier_rx` is 1.
- R10: After the stop-bit sample, the receiver waits for the line to be high before it accepts a new start. A line held low therefore yields only one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| ier_rx | input | 1 | Receive-ready interrupt enable |
| rd_data | input | 1 | Host read strobe for the held byte |
| rd_status | input | 1 | Host read strobe for the status view |
| data_out | output | 8 | Held byte |
| status | output | 5 | {break, framing, parity, overrun, ready} |
| irq | output | 1 | Receive-ready interrupt |

## Verification
A character is written into the holding register one clock after its stop-bit centre sample. The bench therefore waits for the whole stop bit and an idle bit before it checks `data_out` and `status`, well after that write. The strobes `rd_data` and `rd_status` take effect on the next clock edge, so results are sampled on a falling edge after the strobe has been removed. A rejected glitch or a line held low is judged only after a full frame time has passed, so a late false character would have shown up before the check. The data sweep covers all 256 byte values while rotating through no, even and odd parity, with deliberate parity faults mixed in.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int OS     = 16;
    localparam int DATA_W = 8;
    localparam int ST_W   = 5;

    localparam int ST_READY = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_PAR   = 2;
    localparam int ST_FRM   = 3;
    localparam int ST_BRK   = 4;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic par_expect(logic [DATA_W-1:0] d, logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b1;
            dout <= 1'b1;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxs,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_entry_t ent
);
    localparam int CW = $clog2(OS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] HALF_LAST = CW'(OS/2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] sh;
    logic              perr_q;
    logic              hi_seen;
    logic              centre;

    assign centre = (cnt == FULL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            sh      <= '0;
            perr_q  <= 1'b0;
            hi_seen <= 1'b0;
            done    <= 1'b0;
            ent     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxs) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt <= '0;
                            if (!rxs) begin
                                state   <= RX_DATA;
                                bitn    <= '0;
                                perr_q  <= 1'b0;
                                hi_seen <= 1'b0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            sh      <= {rxs, sh[DATA_W-1:1]};
                            hi_seen <= hi_seen | rxs;
                            bitn    <= bitn + 1'b1;
                            if (bitn == BIT_LAST)
                                state <= par_en ? RX_PARITY : RX_STOP;
                        end
                    end
                    RX_PARITY: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            perr_q  <= (rxs != par_expect(sh, par_odd));
                            hi_seen <= hi_seen | rxs;
                            state   <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            done     <= 1'b1;
                            ent.data <= sh;
                            ent.perr <= perr_q;
                            ent.ferr <= !rxs;
                            ent.brk  <= !(hi_seen | rxs);
                            state    <= RX_WAITHI;
                        end
                    end
                    RX_WAITHI: begin
                        if (rxs) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  rx_entry_t         ent_in,
    input  logic              rd_data,
    input  logic              rd_status,
    input  logic              ier_rx,
    output logic [DATA_W-1:0] data_out,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    rx_entry_t held;
    logic      ready;
    logic      ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (wr) begin
                held  <= ent_in;
                ready <= 1'b1;
            end else if (rd_data) begin
                ready <= 1'b0;
            end
            if (wr && ready && !rd_data)
                ovr <= 1'b1;
            else if (rd_status)
                ovr <= 1'b0;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_READY] = ready;
        status[ST_OVR]   = ovr;
        status[ST_PAR]   = held.perr;
        status[ST_FRM]   = held.ferr;
        status[ST_BRK]   = held.brk;
    end

    assign data_out = held.data;
    assign irq      = ready & ier_rx;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ier_rx,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] data_out,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    logic      rxs;
    logic      hold_wr;
    rx_entry_t frame_ent;

    rx_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxs)
    );

    rx_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rxs     (rxs),
        .par_en  (par_en),
        .par_odd (par_odd),
        .done    (hold_wr),
        .ent     (frame_ent)
    );

    rx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr        (hold_wr),
        .ent_in    (frame_ent),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .ier_rx    (ier_rx),
        .data_out  (data_out),
        .status    (status),
        .irq       (irq)
    );
endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              par_en,
    input logic              ier_rx,
    input logic              rd_data,
    input logic              rd_status,
    input logic              hold_wr,
    input logic [DATA_W-1:0] data_out,
    input logic [ST_W-1:0]   status,
    input logic              irq
);
    p_ready_set_r2: assert property (@(posedge clk) disable iff (rst)
        hold_wr |=> status[ST_READY]);

    p_nopar_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_wr && !par_en) |=> !status[ST_PAR]);

    p_brk_implies_frm_r6: assert property (@(posedge clk) disable iff (rst)
        status[ST_BRK] |-> status[ST_FRM]);

    p_ovr_set_r7: assert property (@(posedge clk) disable iff (rst)
        (hold_wr && status[ST_READY] && !rd_data) |=> status[ST_OVR]);

    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !hold_wr) |=> !status[ST_OVR]);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !hold_wr) |=> !status[ST_READY]);

    p_tags_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !hold_wr |=> ($stable(status[ST_BRK:ST_PAR]) && $stable(data_out)));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !ier_rx |-> !irq);

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> status[ST_READY]);
endmodule

bind uart_rx_hold uart_rx_hold_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_en    (par_en),
    .ier_rx    (ier_rx),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .hold_wr   (hold_wr),
    .data_out  (data_out),
    .status    (status),
    .irq       (irq)
);

// File: tb/sim_uart_rx_hold.sv
`timescale 1ns/1ps
module sim_uart_rx_hold;
    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       ier_rx = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] data_out;
    logic [4:0] status;
    logic       irq;

    int  checks = 0;
    int  bad = 0;
    bit  finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) tick <= ~tick;

    uart_rx_hold u0 (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .ier_rx(ier_rx),
        .rd_data(rd_data), .rd_status(rd_status),
        .data_out(data_out), .status(status), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_bit(logic b);
        rxd = b;
        wait_clk(BITCLK);
    endtask

    task automatic send_frame(logic [7:0] d, logic use_par, logic pbit, logic stopb);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (use_par) drive_bit(pbit);
        drive_bit(stopb);
    endtask

    task automatic idle_line();
        drive_bit(1'b1);
    endtask

    task automatic read_data();
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        wait_clk(200000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1: reset state
        check("R1 status", status, 5'b0);
        check("R1 data", data_out, 8'h00);
        check("R1 irq", irq, 1'b0);
        idle_line();

        // R2/R4/R8: sweep every byte, rotating parity mode, with injected faults
        for (int d = 0; d < 256; d++) begin
            int  mode;
            logic flip, pb;
            mode = d % 3;
            flip = (mode != 0) && (d % 7 == 0);
            par_en = (mode != 0);
            par_odd = (mode == 2);
            pb = (^d[7:0]) ^ par_odd ^ flip;
            send_frame(d[7:0], par_en, pb, 1'b1);
            idle_line();
            check("R2 sweep data", data_out, d[7:0]);
            check("R4 sweep status", status, {2'b00, flip, 2'b01});
            read_data();
            check("R8 ready cleared", status[0], 1'b0);
        end

        // R8: tags stay with held byte after read
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h3C, 1'b1, 1'b1, 1'b1);
        idle_line();
        check("R4 even parity error", status, 5'b00101);
        read_data();
        check("R8 tags kept after read", status, 5'b00100);
        check("R8 data kept after read", data_out, 8'h3C);
        send_frame(8'hA7, 1'b1, 1'b1, 1'b1);
        idle_line();
        check("R8 tags follow next byte", status, 5'b00001);
        check("R8 next byte", data_out, 8'hA7);
        read_data();

        // R3: glitch shorter than half a bit is ignored
        par_en = 1'b0;
        rxd = 1'b0; wait_clk(6); rxd = 1'b1;
        wait_clk(12 * BITCLK);
        check("R3 glitch no char", status[0], 1'b0);
        check("R3 glitch data untouched", data_out, 8'hA7);

        // R5: framing error
        send_frame(8'h55, 1'b0, 1'b0, 1'b0);
        idle_line(); idle_line();
        check("R5 framing", status, 5'b01001);
        check("R5 data", data_out, 8'h55);
        read_data();

        // R9: interrupt follows ready and enable
        ier_rx = 1'b1;
        send_frame(8'h81, 1'b0, 1'b0, 1'b1);
        idle_line();
        check("R9 irq set", irq, 1'b1);
        ier_rx = 1'b0; @(negedge clk);
        check("R9 irq masked", irq, 1'b0);
        ier_rx = 1'b1; @(negedge clk);
        read_data();
        check("R9 irq cleared by read", irq, 1'b0);
        ier_rx = 1'b0;

        // R7: overrun
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        idle_line();
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        idle_line();
        check("R7 overrun set", status, 5'b00011);
        check("R7 overwritten data", data_out, 8'h22);
        read_status();
        check("R7 overrun cleared", status[1], 1'b0);
        read_data();

        // R6/R10: break, line held low long
        send_frame(8'h00, 1'b0, 1'b0, 1'b0);
        wait_clk(4 * BITCLK);
        check("R6 break", status, 5'b11001);
        check("R6 data", data_out, 8'h00);
        read_data();
        wait_clk(20 * BITCLK);
        check("R10 no second char", status[0], 1'b0);
        rxd = 1'b1;
        idle_line();
        send_frame(8'hF0, 1'b0, 1'b0, 1'b1);
        idle_line();
        check("R10 rearmed after high", status, 5'b00001);
        check("R10 data", data_out, 8'hF0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule